// File: doc/BRIEF.md
# External Memory Built-In Self-Test Engine

This block is a self-test engine placed between a host-side control and status port and the user command interface of an external memory controller. Once the host asks for a run, the engine waits until two things are true: a power-up settling interval has elapsed since reset, and the controller reports that its calibration is finished. Only then does it issue any traffic.

A run steps through four data phases. Each phase fills a host-chosen address window with one pattern, then reads the same window back in the same address order. Every returned word is compared with a regenerated expected value. Mismatches are counted and the first failing location is kept. At the end the host sees busy, done and pass flags, the error count, the first failing address and the data read from it.

A loop mode repeats the four-phase sequence without clearing results, so that a memory can be exercised for a long time, for example across a temperature sweep. The power-up interval is a parameter of the engine. A fast setting shortens it to a few cycles for simulation.

Top module: `mem_selftest_engine`

## Requirements
- R1: After start, no command (`cmd_valid`) is raised while `calib_done` is low; `busy` is high while waiting, and the first command appears one cycle after `calib_done` is seen high once the power-up interval has expired.
- R2: No command is raised before PWR_CYC cycles have elapsed since reset release, where PWR_CYC = FAST_CYC when SIM_FAST = 1, else WAIT_US * CLK_MHZ.
- R3: Phases run in a fixed order, reported on `phase` as 0 = the 16-bit word 0x0FA5 repeated across the data width, 1 = all zeros, 2 = all ones, 3 = pseudo-random.
- R4: Phase 3 data comes from a 31-bit LFSR with taps x^31 + x^28 + 1. Each step computes new = s[30] ^ s[27] and shifts it in at bit 0. Each data word takes DW steps, and the first new bit lands in data bit 0. The LFSR is reseeded to 31'h2AC51F3B before each write pass and each read pass.
- R5: Each phase writes addresses range_lo up to range_hi in ascending order, then reads the same addresses in the same order. A command is taken only when `cmd_valid` and `cmd_ready` are both high, and `cmd_addr` and `cmd_write` hold while the command is stalled.
- R6: Read data is compared, in arrival order, with the expected word of its address. Each mismatch raises `err_count` by one, and the count saturates at 2^ERR_W - 1.
- R7: `fail_addr` and `fail_data` hold the address and read data of the first mismatch of a run; later mismatches leave them unchanged.
- R8: After reset, `busy`, `done` and `pass` are low. When the last read of phase 3 has returned, `busy` falls and `done` rises, and `pass` is high exactly when `err_count` is zero.
- R9: A start pulse while not busy clears the error count and the first-fail record and captures the address range. A start pulse while busy is ignored.
- R10: If `loop_en` is high when phase 3 completes, phase 0 starts again without clearing results. If it is low, the run ends.
- R11: `rd_valid` pulses outside a read pass do not change the error count or the first-fail record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory user-interface clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| loop_en | input | 1 | Repeat the phase sequence while high |
| range_lo | input | AW | First address of the tested window |
| range_hi | input | AW | Last address of the tested window |
| calib_done | input | 1 | Controller calibration finished |
| cmd_valid | output | 1 | Command request to the controller |
| cmd_ready | input | 1 | Controller accepts a command this cycle |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | AW | Command word address |
| cmd_wdata | output | DW | Write data |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DW | Returned read data |
| busy | output | 1 | Run in progress (including the wait) |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no mismatch |
| phase | output | 2 | Current phase index |
| err_count | output | ERR_W | Saturating mismatch count |
| fail_addr | output | AW | Address of the first mismatch |
| fail_data | output | DW | Data read at the first mismatch |

## Verification
The bench builds the engine with SIM_FAST = 1 and FAST_CYC = 16, so the power-up gate can be measured exactly in a few cycles rather than tens of thousands. It uses AW = 8, so windows that touch the top address of the space are cheap to exercise. It uses ERR_W = 6, so that a looping run with a fault at every address drives the error count into saturation within a few thousand cycles. A memory model with a stalling ready signal, a two-cycle read latency and per-phase fault injection checks the command stream, the regenerated pseudo-random data, and the first-fail record against values the bench derives from the requirements.

// File: rtl/mst_pkg.sv
package mst_pkg;

    typedef enum logic [1:0] {
        PH_FIXED = 2'd0,
        PH_ZERO  = 2'd1,
        PH_ONE   = 2'd2,
        PH_PRBS  = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_DRAIN = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

    localparam logic [15:0] FIXED_WORD = 16'h0FA5;
    localparam logic [30:0] PRBS_SEED  = 31'h2AC51F3B;

    // One LFSR step: feedback from taps 31 and 28, new bit enters at bit 0.
    function automatic logic [30:0] prbs_step(input logic [30:0] s);
        return {s[29:0], s[30] ^ s[27]};
    endfunction

endpackage

// File: rtl/mst_pattern_gen.sv
module mst_pattern_gen
    import mst_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  phase_e        phase,
    output logic [DW-1:0] data
);
    localparam int REPS = DW / 16;

    logic [30:0]   lfsr_q;
    logic [DW-1:0] word_q;
    logic [30:0]   walk;
    logic [DW-1:0] word_n;

    // Produce one full word: DW steps from either the seed or the live state.
    always_comb begin
        walk = load ? PRBS_SEED : lfsr_q;
        for (int i = 0; i < DW; i++) begin
            walk      = prbs_step(walk);
            word_n[i] = walk[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= PRBS_SEED;
            word_q <= '0;
        end else if (load || adv) begin
            lfsr_q <= walk;
            word_q <= word_n;
        end
    end

    always_comb begin
        unique case (phase)
            PH_FIXED: data = {REPS{FIXED_WORD}};
            PH_ZERO:  data = '0;
            PH_ONE:   data = '1;
            default:  data = word_q;
        endcase
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0); // R4

endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
    parameter int DW    = 32,
    parameter int AW    = 12,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             arm,
    input  logic             window,
    input  logic [AW-1:0]    lo,
    input  logic [AW-1:0]    hi,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    input  logic [DW-1:0]    exp_data,
    output logic             adv,
    output logic             last,
    output logic [ERR_W-1:0] err_cnt,
    output logic             fail_seen,
    output logic [AW-1:0]    fail_addr,
    output logic [DW-1:0]    fail_data
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic [AW-1:0] ptr_q;
    logic          mism;

    assign adv  = rd_valid && window;
    assign last = adv && (ptr_q == hi);
    assign mism = adv && (rd_data != exp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            err_cnt   <= '0;
            fail_seen <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
        end else begin
            if (arm) begin
                ptr_q <= lo;
            end else if (adv) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (clear) begin
                err_cnt   <= '0;
                fail_seen <= 1'b0;
                fail_addr <= '0;
                fail_data <= '0;
            end else if (mism) begin
                if (err_cnt != ERR_MAX) begin
                    err_cnt <= err_cnt + 1'b1;
                end
                if (!fail_seen) begin
                    fail_seen <= 1'b1;
                    fail_addr <= ptr_q;
                    fail_data <= rd_data;
                end
            end
        end
    end

    AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (err_cnt == ERR_MAX && !clear) |=> err_cnt == ERR_MAX); // R6

    AST_FIRST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
        (fail_seen && !clear) |=> $stable(fail_addr) && $stable(fail_data)); // R7

    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!window && !clear) |=> $stable(err_cnt) && $stable(fail_seen)); // R11

endmodule

// File: rtl/mst_sequencer.sv
module mst_sequencer
    import mst_pkg::*;
#(
    parameter int AW      = 12,
    parameter int PWR_CYC = 40000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          loop_en,
    input  logic          calib_done,
    input  logic          cmd_ready,
    input  logic [AW-1:0] range_lo,
    input  logic [AW-1:0] range_hi,
    input  logic          chk_last,
    output logic          cmd_valid,
    output logic          cmd_write,
    output logic [AW-1:0] cmd_addr,
    output phase_e        phase,
    output logic          busy,
    output logic          done,
    output logic          gen_load,
    output logic          gen_adv,
    output logic          chk_arm,
    output logic          rd_window,
    output logic          clear,
    output logic [AW-1:0] lo_q,
    output logic [AW-1:0] hi_q
);
    localparam int CW = $clog2(PWR_CYC + 1);

    seq_state_e    state_q;
    logic [CW-1:0] pwr_cnt;
    logic          pwr_ok;
    logic          fire;
    logic          at_hi;
    logic          go_test;
    logic          phase_end;
    logic          restart;

    // Power-up interval counted from reset release, then held.
    assign pwr_ok = (pwr_cnt == CW'(PWR_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_cnt <= '0;
        end else if (!pwr_ok) begin
            pwr_cnt <= pwr_cnt + 1'b1;
        end
    end

    assign cmd_valid = (state_q == ST_WRITE) || (state_q == ST_READ);
    assign cmd_write = (state_q == ST_WRITE);
    assign fire      = cmd_valid && cmd_ready;
    assign at_hi     = (cmd_addr == hi_q);
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);
    assign rd_window = (state_q == ST_READ) || (state_q == ST_DRAIN);
    assign clear     = start && !busy;
    assign go_test   = (state_q == ST_WAIT) && pwr_ok && calib_done;
    assign phase_end = (state_q == ST_DRAIN) && chk_last;
    assign restart   = phase_end && ((phase != PH_PRBS) || loop_en);
    assign chk_arm   = (state_q == ST_WRITE) && fire && at_hi;
    assign gen_load  = go_test || chk_arm || restart;
    assign gen_adv   = fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase    <= PH_FIXED;
            cmd_addr <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        lo_q    <= range_lo;
                        hi_q    <= range_hi;
                        phase   <= PH_FIXED;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (go_test) begin
                        cmd_addr <= lo_q;
                        state_q  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (fire) begin
                        if (at_hi) begin
                            cmd_addr <= lo_q;
                            state_q  <= ST_READ;
                        end else begin
                            cmd_addr <= cmd_addr + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (fire) begin
                        if (at_hi) begin
                            state_q <= ST_DRAIN;
                        end else begin
                            cmd_addr <= cmd_addr + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (phase_end) begin
                        if (restart) begin
                            phase    <= (phase == PH_PRBS) ? PH_FIXED : phase_e'(phase + 2'd1);
                            cmd_addr <= lo_q;
                            state_q  <= ST_WRITE;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CAL_GATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !calib_done) |=> !cmd_valid); // R1

    AST_PWR_GATE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> pwr_ok); // R2

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_write)); // R5

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R8

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(lo_q) && $stable(hi_q)); // R9

endmodule

// File: rtl/mem_selftest_engine.sv
module mem_selftest_engine
    import mst_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 12,
    parameter int ERR_W    = 16,
    parameter int CLK_MHZ  = 200,
    parameter int WAIT_US  = 200,
    parameter bit SIM_FAST = 1'b0,
    parameter int FAST_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             loop_en,
    input  logic [AW-1:0]    range_lo,
    input  logic [AW-1:0]    range_hi,
    input  logic             calib_done,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic             cmd_write,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_wdata,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [1:0]       phase,
    output logic [ERR_W-1:0] err_count,
    output logic [AW-1:0]    fail_addr,
    output logic [DW-1:0]    fail_data
);
    localparam int PWR_CYC = SIM_FAST ? FAST_CYC : WAIT_US * CLK_MHZ;

    phase_e        phase_w;
    logic          gen_load, gen_adv, chk_arm, rd_window, clear;
    logic          chk_adv, chk_last, fail_seen;
    logic [AW-1:0] lo_q, hi_q;
    logic [DW-1:0] exp_data;

    mst_sequencer #(.AW(AW), .PWR_CYC(PWR_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .loop_en    (loop_en),
        .calib_done (calib_done),
        .cmd_ready  (cmd_ready),
        .range_lo   (range_lo),
        .range_hi   (range_hi),
        .chk_last   (chk_last),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_addr   (cmd_addr),
        .phase      (phase_w),
        .busy       (busy),
        .done       (done),
        .gen_load   (gen_load),
        .gen_adv    (gen_adv),
        .chk_arm    (chk_arm),
        .rd_window  (rd_window),
        .clear      (clear),
        .lo_q       (lo_q),
        .hi_q       (hi_q)
    );

    // Issue-side generator: drives write data.
    mst_pattern_gen #(.DW(DW)) u_gen_issue (
        .clk   (clk),
        .rst   (rst),
        .load  (gen_load),
        .adv   (gen_adv),
        .phase (phase_w),
        .data  (cmd_wdata)
    );

    // Check-side generator: regenerates expected read data in arrival order.
    mst_pattern_gen #(.DW(DW)) u_gen_check (
        .clk   (clk),
        .rst   (rst),
        .load  (chk_arm),
        .adv   (chk_adv),
        .phase (phase_w),
        .data  (exp_data)
    );

    mst_checker #(.DW(DW), .AW(AW), .ERR_W(ERR_W)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .arm       (chk_arm),
        .window    (rd_window),
        .lo        (lo_q),
        .hi        (hi_q),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .exp_data  (exp_data),
        .adv       (chk_adv),
        .last      (chk_last),
        .err_cnt   (err_count),
        .fail_seen (fail_seen),
        .fail_addr (fail_addr),
        .fail_data (fail_data)
    );

    assign phase = phase_w;
    assign pass  = done && (err_count == '0);

    AST_PASS_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        pass |-> !fail_seen); // R8

endmodule

// File: tb/test_mem_selftest_engine.sv
module test_mem_selftest_engine;
    localparam int CLK_PERIOD = 4;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int ERR_W = 6;
    localparam int FAST_CYC = 16;
    localparam logic [31:0] FLIP = 32'h0000_0100;
    localparam int WD_LIMIT = 150000;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] fa;
        logic [3:0] fm;
        logic       stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{lo: 8'd8,   hi: 8'd40,  fa: 8'd20,  fm: 4'b0001, stall: 1'b1},
        '{lo: 8'd100, hi: 8'd131, fa: 8'd131, fm: 4'b1000, stall: 1'b1},
        '{lo: 8'd50,  hi: 8'd50,  fa: 8'd50,  fm: 4'b0110, stall: 1'b0},
        '{lo: 8'd200, hi: 8'd255, fa: 8'd210, fm: 4'b1111, stall: 1'b1},
        '{lo: 8'd0,   hi: 8'd7,   fa: 8'd3,   fm: 4'b1010, stall: 1'b0},
        '{lo: 8'd0,   hi: 8'd15,  fa: 8'd99,  fm: 4'b1111, stall: 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, loop_en = 1'b0, calib_done = 1'b0;
    logic [AW-1:0] range_lo = '0, range_hi = '0;
    logic cmd_valid, cmd_write, busy, done, pass;
    logic cmd_ready = 1'b1;
    logic [AW-1:0] cmd_addr, fail_addr;
    logic [DW-1:0] cmd_wdata, rd_data, fail_data;
    logic rd_valid;
    logic [1:0] phase;
    logic [ERR_W-1:0] err_count;

    int n_checks = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_selftest_engine #(.DW(DW), .AW(AW), .ERR_W(ERR_W), .SIM_FAST(1'b1), .FAST_CYC(FAST_CYC))
    i_mem_selftest_engine (
        .clk(clk), .rst(rst), .start(start), .loop_en(loop_en),
        .range_lo(range_lo), .range_hi(range_hi), .calib_done(calib_done),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .pass(pass), .phase(phase), .err_count(err_count),
        .fail_addr(fail_addr), .fail_data(fail_data)
    );

    // ---------------- expected pattern table (from R3/R4) ----------------
    logic [31:0] prbs_tab [256];
    initial begin
        logic [30:0] s;
        s = 31'h2AC51F3B;
        for (int w = 0; w < 256; w++) begin
            for (int b = 0; b < 32; b++) begin
                logic nb;
                nb = s[30] ^ s[27];
                s = {s[29:0], nb};
                prbs_tab[w][b] = nb;
            end
        end
    end

    function automatic logic [31:0] exp_word(input int ph, input int idx);
        case (ph)
            0: return {2{16'h0FA5}};
            1: return 32'h0;
            2: return 32'hFFFF_FFFF;
            default: return prbs_tab[idx];
        endcase
    endfunction

    // ---------------- memory model with fault injection ----------------
    logic [31:0] mem [256];
    logic p1_v, p2_v;
    logic [7:0] p1_a, p2_a;
    logic stall_en = 1'b0, fault_all = 1'b0;
    logic [7:0] fault_addr = '0;
    logic [3:0] fault_mask = '0;
    logic inj_v = 1'b0;
    logic [31:0] inj_d = '0;
    logic fault_hit;

    always @(posedge clk) begin
        if (cmd_valid && cmd_ready && cmd_write) mem[cmd_addr] <= cmd_wdata;
        if (rst) begin
            p1_v <= 1'b0; p2_v <= 1'b0; p1_a <= '0; p2_a <= '0;
        end else begin
            p1_v <= cmd_valid && cmd_ready && !cmd_write;
            p1_a <= cmd_addr;
            p2_v <= p1_v;
            p2_a <= p1_a;
        end
        cmd_ready <= stall_en ? ((cyc % 5) != 3 && (cyc % 7) != 2) : 1'b1;
    end

    assign fault_hit = p2_v && fault_mask[phase] && (fault_all || p2_a == fault_addr);
    assign rd_valid  = p2_v || inj_v;
    assign rd_data   = inj_v ? inj_d : (mem[p2_a] ^ (fault_hit ? FLIP : 32'h0));

    // ---------------- command stream monitor (R3, R4, R5) ----------------
    int mon_lo, mon_hi, mon_addr, mon_phase, mon_wraps, cv_cnt;
    logic mon_wr;
    int bad_addr, bad_data, bad_phase;

    task automatic mon_reset(input int lo, input int hi);
        mon_lo = lo; mon_hi = hi; mon_addr = lo; mon_phase = 0; mon_wr = 1'b1;
        mon_wraps = 0; bad_addr = 0; bad_data = 0; bad_phase = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cmd_valid) cv_cnt++;
        if (!rst && cmd_valid && cmd_ready) begin
            if (cmd_addr != mon_addr[7:0] || cmd_write != mon_wr) bad_addr++;
            if (phase != mon_phase[1:0]) bad_phase++;
            if (cmd_write && cmd_wdata != exp_word(mon_phase, mon_addr - mon_lo)) bad_data++;
            if (mon_addr == mon_hi) begin
                mon_addr = mon_lo;
                if (!mon_wr) begin
                    if (mon_phase == 3) begin mon_phase = 0; mon_wraps++; end
                    else mon_phase++;
                end
                mon_wr = !mon_wr;
            end else begin
                mon_addr++;
            end
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            summary_and_end();
        end
    end

    task automatic pulse_start(input int lo, input int hi);
        range_lo = lo[7:0]; range_hi = hi[7:0];
        mon_reset(lo, hi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    endtask

    task automatic check_stream(input string tag);
        chk(bad_addr == 0, "R5", {tag, " address/order mismatches"}, bad_addr, 0);
        chk(bad_phase == 0, "R3", {tag, " phase order mismatches"}, bad_phase, 0);
        chk(bad_data == 0, "R4", {tag, " write data mismatches"}, bad_data, 0);
    endtask

    task automatic run_vec(input vec_t v);
        int ne, first_ph;
        logic in_rng;
        in_rng = (v.fa >= v.lo) && (v.fa <= v.hi);
        ne = 0; first_ph = -1;
        for (int p = 0; p < 4; p++) begin
            if (v.fm[p] && in_rng) begin
                ne++;
                if (first_ph < 0) first_ph = p;
            end
        end
        fault_addr = v.fa; fault_mask = v.fm; stall_en = v.stall; fault_all = 1'b0;
        pulse_start(v.lo, v.hi);
        chk(err_count == 0 && busy, "R9", "results cleared on start", err_count, 0);
        wait_done();
        chk(done && !busy, "R8", "done after run", {busy, done}, 2'b01);
        chk(err_count == ne[ERR_W-1:0], "R6", "error count", err_count, ne);
        chk(pass == (ne == 0), "R8", "pass flag", pass, ne == 0);
        if (ne > 0) begin
            chk(fail_addr == v.fa, "R7", "first fail address", fail_addr, v.fa);
            chk(fail_data == (exp_word(first_ph, v.fa - v.lo) ^ FLIP), "R7", "first fail data",
                fail_data, exp_word(first_ph, v.fa - v.lo) ^ FLIP);
        end
        check_stream("vector");
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int t;
        logic [ERR_W-1:0] e_keep;
        logic [AW-1:0] a_keep;

        // Reset state (R8)
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass && !cmd_valid && err_count == 0, "R8", "reset state",
            {busy, done, pass, cmd_valid}, 0);

        // Power-up gate (R2): calibration already done, start right after release
        calib_done = 1'b1;
        rst = 1'b0;
        pulse_start(0, 3);
        t = 1;
        while (!cmd_valid && t < 200) begin @(negedge clk); t++; end
        chk(t >= FAST_CYC && t <= FAST_CYC + 2, "R2", "cycles to first command", t, FAST_CYC + 1);
        wait_done();
        chk(pass, "R8", "short run passes", pass, 1);

        // Calibration gate (R1)
        calib_done = 1'b0;
        pulse_start(0, 3);
        cv_cnt = 0;
        repeat (40) @(negedge clk);
        chk(cv_cnt == 0, "R1", "commands before calibration", cv_cnt, 0);
        chk(busy && !done, "R1", "busy while waiting", {busy, done}, 2'b10);
        calib_done = 1'b1;
        @(negedge clk);
        chk(cmd_valid, "R1", "command one cycle after calibration", cmd_valid, 1);
        wait_done();
        check_stream("cal-gate run");

        // Vector table (R3..R9)
        foreach (VECS[i]) run_vec(VECS[i]);

        // Read data outside a read pass is ignored (R11)
        e_keep = err_count; a_keep = fail_addr;
        inj_d = 32'hDEAD_BEEF; inj_v = 1'b1;
        repeat (3) @(negedge clk);
        inj_v = 1'b0;
        @(negedge clk);
        chk(err_count == e_keep && fail_addr == a_keep && pass, "R11", "stray read data",
            err_count, e_keep);

        // Start while busy is ignored (R9)
        fault_addr = 8'd12; fault_mask = 4'b1111; stall_en = 1'b1; fault_all = 1'b0;
        pulse_start(10, 20);
        while (phase != 2'd2) @(negedge clk);
        range_lo = 8'd0; range_hi = 8'd2;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        chk(err_count == 4, "R9", "start while busy ignored, count", err_count, 4);
        chk(fail_addr == 12, "R9", "start while busy ignored, address", fail_addr, 12);
        check_stream("busy-start run");

        // Loop mode and saturation (R10, R6)
        fault_all = 1'b1; fault_mask = 4'b1111; stall_en = 1'b0; loop_en = 1'b1;
        pulse_start(0, 3);
        t = 0;
        while (mon_wraps < 5 && t < 20000) begin @(negedge clk); t++; end
        chk(mon_wraps >= 5, "R10", "sequence restarts at phase 0", mon_wraps, 5);
        chk(busy && !done, "R10", "still running in loop mode", {busy, done}, 2'b10);
        loop_en = 1'b0;
        wait_done();
        chk(done, "R10", "run ends after loop disabled", done, 1);
        chk(err_count == {ERR_W{1'b1}}, "R6", "saturated error count", err_count, {ERR_W{1'b1}});
        chk(fail_addr == 0 && fail_data == ({2{16'h0FA5}} ^ FLIP), "R7",
            "first fail kept across loops", fail_data, {2{16'h0FA5}} ^ FLIP);
        check_stream("loop run");
        fault_all = 1'b0;

        summary_and_end();
    end

endmodule